// File: doc/BRIEF.md
# Real-Time Clock Core with Coherent Time Readout

This block keeps wall-clock time for a chip. It runs on the system clock and advances on a one-cycle enable pulse that arrives at 32.768 kHz. From that enable it derives a 1 kHz milliseconds stream by fractional accumulation. It keeps a live milliseconds counter (0 to 999) and a live seconds counter.

The live counters are not visible to the bus. After every eighth 32 kHz enable, the block raises a busy flag for one cycle. In that cycle it copies the live seconds and milliseconds to bus-side registers. A read of the milliseconds register captures the bus-side seconds into a shadow register, so software can read milliseconds and then shadow seconds and get a matching pair. The time, alarm and mask registers accept writes only while busy is low.

A seconds alarm compares the live seconds against a programmed value; zero disables it. A match sets a status bit, which software clears by writing 1 to it. A level-high interrupt reports any status bit that is enabled by its mask bit.

Top module: `rtc_shadow_core`

## Requirements
- R1: The busy flag (output `busy_o`, and bit 0 of address 0x04) goes high for exactly one cycle after the clock edge that samples the eighth, sixteenth, and so on, asserted `tick_32k` since reset. The bus-side copy takes place in that cycle.
- R2: A read of address 0x10 (milliseconds) loads the bus-side seconds value into the shadow register at address 0x0C. The shadow register keeps that value until the next milliseconds read.
- R3: A write to seconds (0x08), alarm (0x14) or mask (0x28) that is sampled while busy is high is dropped. The target register keeps its previous value.
- R4: Status (0x2C) is write-1-to-clear, and writing 0x1F clears every pending bit. The bit layout is: bit 0 seconds alarm 0, bit 1 seconds alarm 1, bit 2 milliseconds alarm, bit 3 seconds countdown, bit 4 milliseconds countdown. Hardware sets only bit 0; bits 1 to 4 always read as 0.
- R5: When the alarm register holds zero, status bit 0 is never set, whatever the seconds value.
- R6: While the alarm register is nonzero and equal to the live seconds counter, status bit 0 becomes set on the next clock edge.
- R7: `irq_o` is high exactly when some status bit and the mask bit in the same position (0x28, same layout as R4) are both 1.
- R8: The milliseconds counter advances once per 1000/32768 share of the 32 kHz enables, counts 0 to 999, then wraps to 0 and increments seconds. After 32760 enables from reset, the bus side shows 0 s and 999 ms. After 32768 enables it shows 1 s and 0 ms.
- R9: Reset clears the counters, the bus-side and shadow values, the alarm, the mask and the status, and drops busy and the interrupt.
- R10: If hardware sets a status bit in the same cycle that a write-1 clears it, the bit stays set.
- R11: Address map: busy 0x04, seconds 0x08, shadow 0x0C, milliseconds 0x10, alarm 0x14, mask 0x28, status 0x2C. All other addresses read as zero.
- R12: A write to seconds that busy does not block loads the live seconds counter. The new value appears at 0x08 after the next copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at 32.768 kHz |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for the shadow capture) |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| busy_o | output | 1 | Copy window in progress |
| irq_o | output | 1 | Level-high interrupt |

## Verification
Two events can land in the same cycle: a hardware alarm match setting status bit 0, and a software write-1 clearing that bit. The bench arranges this by keeping the live seconds equal to the alarm value while it writes 1 to status. It then expects bit 0 to read back as 1. After moving the alarm away and writing again, it expects bit 0 to read as 0. A second collision is a write placed in the busy cycle. The bench waits out the eighth enable, drives an alarm write while busy is visibly high, and expects the old alarm value to read back.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int AW    = 8;
    localparam int INT_W = 5;

    localparam logic [AW-1:0] ADDR_BUSY   = 8'h04;
    localparam logic [AW-1:0] ADDR_SEC    = 8'h08;
    localparam logic [AW-1:0] ADDR_SHADOW = 8'h0C;
    localparam logic [AW-1:0] ADDR_MSEC   = 8'h10;
    localparam logic [AW-1:0] ADDR_ALARM0 = 8'h14;
    localparam logic [AW-1:0] ADDR_MASK   = 8'h28;
    localparam logic [AW-1:0] ADDR_STATUS = 8'h2C;

    // interrupt bit positions (status and mask share them)
    localparam int IRQ_SEC_ALM0 = 0;
    localparam int IRQ_SEC_ALM1 = 1;
    localparam int IRQ_MS_ALM   = 2;
    localparam int IRQ_SEC_CDN  = 3;
    localparam int IRQ_MS_CDN   = 4;
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int TICK_HZ    = 32768,
    parameter int MS_HZ      = 1000,
    parameter int COPY_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_32k,
    output logic ms_tick,
    output logic copy_req
);
    localparam int ACC_W = $clog2(TICK_HZ) + 1;
    localparam int PH_W  = (COPY_TICKS > 1) ? $clog2(COPY_TICKS) : 1;
    localparam logic [ACC_W:0]  STEP    = (ACC_W+1)'(MS_HZ);
    localparam logic [ACC_W:0]  WRAP    = (ACC_W+1)'(TICK_HZ);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(COPY_TICKS - 1);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [PH_W-1:0]  phase;
    } div_t;

    div_t q, d;
    logic [ACC_W:0] sum;

    always_comb begin
        d        = q;
        sum      = {1'b0, q.acc} + STEP;
        ms_tick  = tick_32k && (sum >= WRAP);
        copy_req = tick_32k && (q.phase == PH_LAST);
        if (tick_32k) begin
            d.acc   = ms_tick ? ACC_W'(sum - WRAP) : ACC_W'(sum);
            d.phase = copy_req ? '0 : q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/rtc_time_count.sv
module rtc_time_count #(
    parameter int SEC_W = 32,
    parameter int MS_HZ = 1000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ms_tick,
    input  logic                       sec_load,
    input  logic [SEC_W-1:0]           sec_val,
    output logic [SEC_W-1:0]           sec,
    output logic [$clog2(MS_HZ)-1:0]   ms
);
    localparam int MS_W = $clog2(MS_HZ);
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_HZ - 1);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MS_W-1:0]  ms;
    } cnt_t;

    cnt_t q, d;

    always_comb begin
        d = q;
        if (ms_tick) begin
            if (q.ms == MS_LAST) begin
                d.ms  = '0;
                d.sec = q.sec + 1'b1;
            end else begin
                d.ms = q.ms + 1'b1;
            end
        end
        // a software load overrides the carry into seconds
        if (sec_load) d.sec = sec_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sec = q.sec;
    assign ms  = q.ms;
endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
    import rtc_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int MS_W  = 10,
    parameter int DW    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    input  logic               copy_req,
    input  logic [SEC_W-1:0]   live_sec,
    input  logic [MS_W-1:0]    live_ms,
    output logic               sec_load,
    output logic [SEC_W-1:0]   sec_val,
    output logic               busy,
    output logic [SEC_W-1:0]   bus_sec,
    output logic [SEC_W-1:0]   shadow,
    output logic [SEC_W-1:0]   alarm,
    output logic [INT_W-1:0]   mask,
    output logic [INT_W-1:0]   status,
    output logic               irq
);
    typedef struct packed {
        logic             busy;
        logic [SEC_W-1:0] bus_sec;
        logic [MS_W-1:0]  bus_ms;
        logic [SEC_W-1:0] shadow;
        logic [SEC_W-1:0] alarm;
        logic [INT_W-1:0] mask;
        logic [INT_W-1:0] status;
    } regs_t;

    regs_t q, d;
    logic             wr_ok;
    logic             alarm_hit;
    logic [INT_W-1:0] set_v;
    logic [INT_W-1:0] clr_v;

    always_comb begin
        d         = q;
        wr_ok     = wr_en && !q.busy;
        alarm_hit = (q.alarm != '0) && (live_sec == q.alarm);
        set_v     = '0;
        set_v[IRQ_SEC_ALM0] = alarm_hit;
        clr_v     = (wr_en && addr == ADDR_STATUS) ? wdata[INT_W-1:0] : '0;

        d.busy = copy_req;
        if (q.busy) begin
            d.bus_sec = live_sec;
            d.bus_ms  = live_ms;
        end
        if (rd_en && addr == ADDR_MSEC) d.shadow = q.bus_sec;
        if (wr_ok && addr == ADDR_ALARM0) d.alarm = wdata[SEC_W-1:0];
        if (wr_ok && addr == ADDR_MASK)   d.mask  = wdata[INT_W-1:0];
        // set beats clear when both hit one bit in the same cycle
        d.status = (q.status & ~clr_v) | set_v;

        sec_load = wr_ok && (addr == ADDR_SEC);
        sec_val  = wdata[SEC_W-1:0];
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_BUSY:   rdata[0] = q.busy;
            ADDR_SEC:    rdata = DW'(q.bus_sec);
            ADDR_SHADOW: rdata = DW'(q.shadow);
            ADDR_MSEC:   rdata = DW'(q.bus_ms);
            ADDR_ALARM0: rdata = DW'(q.alarm);
            ADDR_MASK:   rdata = DW'(q.mask);
            ADDR_STATUS: rdata = DW'(q.status);
            default:     rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign bus_sec = q.bus_sec;
    assign shadow  = q.shadow;
    assign alarm   = q.alarm;
    assign mask    = q.mask;
    assign status  = q.status;
    assign irq     = |(q.status & q.mask);
endmodule

// File: rtl/rtc_shadow_core.sv
module rtc_shadow_core
    import rtc_pkg::*;
#(
    parameter int TICK_HZ    = 32768,
    parameter int MS_HZ      = 1000,
    parameter int COPY_TICKS = 8,
    parameter int SEC_W      = 32,
    parameter int DW         = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_32k,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          busy_o,
    output logic          irq_o
);
    localparam int MS_W = $clog2(MS_HZ);

    logic             ms_tick;
    logic             copy_req;
    logic             sec_load;
    logic [SEC_W-1:0] sec_val;
    logic [SEC_W-1:0] live_sec;
    logic [MS_W-1:0]  live_ms;
    logic [SEC_W-1:0] bus_sec;
    logic [SEC_W-1:0] shadow;
    logic [SEC_W-1:0] alarm;
    logic [INT_W-1:0] mask;
    logic [INT_W-1:0] status;

    rtc_tick_div #(
        .TICK_HZ(TICK_HZ), .MS_HZ(MS_HZ), .COPY_TICKS(COPY_TICKS)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k),
        .ms_tick(ms_tick), .copy_req(copy_req)
    );

    rtc_time_count #(.SEC_W(SEC_W), .MS_HZ(MS_HZ)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .sec_load(sec_load), .sec_val(sec_val),
        .sec(live_sec), .ms(live_ms)
    );

    rtc_bus_regs #(.SEC_W(SEC_W), .MS_W(MS_W), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .copy_req(copy_req), .live_sec(live_sec), .live_ms(live_ms),
        .sec_load(sec_load), .sec_val(sec_val),
        .busy(busy_o), .bus_sec(bus_sec), .shadow(shadow), .alarm(alarm),
        .mask(mask), .status(status), .irq(irq_o)
    );
endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk
    import rtc_pkg::*;
#(
    parameter int SEC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [AW-1:0]    addr,
    input logic             busy,
    input logic [SEC_W-1:0] live_sec,
    input logic [SEC_W-1:0] bus_sec,
    input logic [SEC_W-1:0] shadow,
    input logic [SEC_W-1:0] alarm,
    input logic [INT_W-1:0] status,
    input logic             irq
);
    assert_busy_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    assert_shadow_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_MSEC) |=> (shadow == $past(bus_sec)));

    assert_gated_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_ALARM0 && busy) |=> $stable(alarm));

    assert_reserved_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status[INT_W-1:1] == '0);

    // match sets bit 0 next edge, even against a same-cycle clear (R10)
    assert_alarm_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm != '0 && live_sec == alarm) |=> status[IRQ_SEC_ALM0]);

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status[IRQ_SEC_ALM0]);
endmodule

bind rtc_shadow_core rtc_shadow_chk #(.SEC_W(SEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .busy(busy_o), .live_sec(live_sec), .bus_sec(bus_sec), .shadow(shadow),
    .alarm(alarm), .status(status), .irq(irq_o)
);

// File: tb/sim_rtc_shadow_core.sv
`timescale 1ns/1ps
module sim_rtc_shadow_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_32k = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        busy_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rtc_shadow_core u0 (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .busy_o(busy_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick_32k = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        while (busy_o) @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        tick_32k = 1'b1;
        repeat (n) @(negedge clk);
        tick_32k = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        check("R9", "busy", {31'b0, busy_o}, 0);
        check("R9", "irq", {31'b0, irq_o}, 0);
        rd(8'h08, v); check("R9", "seconds", v, 0);
        rd(8'h14, v); check("R9", "alarm", v, 0);
        rd(8'h28, v); check("R9", "mask", v, 0);
        rd(8'h2C, v); check("R9", "status", v, 0);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        do_reset();
        tick_32k = 1'b1;
        repeat (7) @(negedge clk);
        tick_32k = 1'b0;
        check("R1", "busy after 7 ticks", {31'b0, busy_o}, 0);
        tick_32k = 1'b1;
        @(negedge clk);
        tick_32k = 1'b0;
        check("R1", "busy after 8th tick", {31'b0, busy_o}, 1);
        rd_en = 1'b1; addr = 8'h04;
        #1 check("R1", "busy register bit", rdata, 1);
        rd_en = 1'b0;
        // write placed in the busy cycle must be dropped
        wr_en = 1'b1; addr = 8'h14; wdata = 32'd77;
        @(negedge clk);
        wr_en = 1'b0;
        check("R1", "busy one cycle only", {31'b0, busy_o}, 0);
        rd(8'h14, v); check("R3", "alarm write during busy", v, 0);
        wr(8'h14, 32'd77);
        rd(8'h14, v); check("R3", "alarm write when idle", v, 77);
    endtask

    task automatic t_count();
        logic [31:0] v;
        do_reset();
        run_ticks(32760);
        rd(8'h10, v); check("R8", "ms after 32760 ticks", v, 999);
        rd(8'h0C, v); check("R8", "shadow sec after 32760", v, 0);
        run_ticks(8);
        rd(8'h08, v); check("R8", "sec after 32768 ticks", v, 1);
        rd(8'h10, v); check("R8", "ms after wrap", v, 0);
    endtask

    task automatic t_shadow();
        logic [31:0] v;
        do_reset();
        wr(8'h08, 32'd100);
        rd(8'h08, v); check("R12", "seconds before copy", v, 0);
        run_ticks(8);
        rd(8'h08, v); check("R12", "seconds after copy", v, 100);
        rd(8'h10, v);
        wr(8'h08, 32'd200);
        run_ticks(8);
        rd(8'h0C, v); check("R2", "shadow held", v, 100);
        rd(8'h08, v); check("R12", "second load", v, 200);
        rd(8'h10, v);
        rd(8'h0C, v); check("R2", "shadow recaptured", v, 200);
    endtask

    task automatic t_alarm();
        logic [31:0] v;
        do_reset();
        wr(8'h28, 32'h1);
        wr(8'h14, 32'd5);
        rd(8'h2C, v); check("R6", "no match yet", v, 0);
        wr(8'h08, 32'd5);
        @(negedge clk);
        check("R7", "irq on match", {31'b0, irq_o}, 1);
        rd(8'h2C, v); check("R6", "status on match", v, 1);
        wr(8'h2C, 32'h1);
        rd(8'h2C, v); check("R10", "set wins over clear", v, 1);
        wr(8'h14, 32'd9);
        wr(8'h2C, 32'h1F);
        rd(8'h2C, v); check("R4", "clear all", v, 0);
        check("R4", "irq after clear", {31'b0, irq_o}, 0);
    endtask

    task automatic t_zero_alarm();
        logic [31:0] v;
        do_reset();
        wr(8'h28, 32'h1F);
        wr(8'h08, 32'd0);
        repeat (4) @(negedge clk);
        rd(8'h2C, v); check("R5", "zero alarm no status", v, 0);
        check("R5", "zero alarm no irq", {31'b0, irq_o}, 0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        do_reset();
        wr(8'h14, 32'd3);
        wr(8'h08, 32'd3);
        @(negedge clk);
        rd(8'h2C, v); check("R4", "only bit0 set", v, 1);
        check("R7", "masked irq low", {31'b0, irq_o}, 0);
        wr(8'h28, 32'hFF);
        rd(8'h28, v); check("R7", "mask readback", v, 32'h1F);
        check("R7", "unmasked irq high", {31'b0, irq_o}, 1);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(8'h00, v); check("R11", "addr 00", v, 0);
        rd(8'h20, v); check("R11", "addr 20", v, 0);
        rd(8'hFC, v); check("R11", "addr FC", v, 0);
    endtask

    initial begin
        t_reset();
        t_busy();
        t_count();
        t_shadow();
        t_alarm();
        t_zero_alarm();
        t_mask();
        t_unmapped();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule